// File: doc/BRIEF.md
# Dual Digital Trigger Detector

This block decides when a sweep may start, working on sampled digital waveforms. It holds two independent trigger channels, a main one and a delayed one. Each channel picks one of six sources with a 3-bit select code: four input channels, the saturated sum of channels 1 and 2, or a line-rate reference. It compares the picked sample against a programmed level and fires on the edge that a stored slope setting selects.

A channel is armed only while its holdoff input is low. When a qualifying crossing occurs, the channel pulls its active-low gate and active-low status outputs low. Both stay low, whatever the source does, until holdoff goes high again. Holdoff high clears the channel and keeps it disarmed.

Slope, an auto-trigger enable and an auto timeout are kept in a per-channel control register. That register changes only when the channel's own load strobe is pulsed. With auto enabled, a channel that sees no crossing fires anyway once the timeout expires.

Top module: `dual_trig_unit`

## Requirements
- R1: After reset, all four trigger outputs are high and both control registers hold slope 0, auto off and timeout 0.
- R2: The select code {bit2,bit1,bit0} picks the source as follows: 110 gives channel 1, 101 gives channel 2, 100 gives the sum of channels 1 and 2, 010 gives channel 3, 001 gives channel 4, and 111 gives the line source. A crossing on a source that is not selected has no effect.
- R3: The sum source is the unsigned sum of channel 1 and channel 2, clamped to the all-ones value of the sample width.
- R4: With slope 0, a trigger occurs when the previous armed sample is below the level and the current sample is at or above it (unsigned).
- R5: With slope 1, a trigger occurs when the previous armed sample is at or above the level and the current sample is below it.
- R6: At the first armed edge after holdoff goes low, the sample is only captured and cannot cause a crossing. Once fired, the outputs stay low until holdoff is sampled high, and they return high at that edge. While holdoff is high, no trigger can occur.
- R7: Select codes 000 and 011 never produce a trigger, whether from a crossing or from auto timeout.
- R8: With auto on and timeout T > 0, a channel that has no crossing fires at the T-th consecutive armed edge with a valid select code. T = 0 disables auto firing.
- R9: The control register of a channel loads {slope, auto, timeout} only at an edge where that channel's load strobe is high. The two channels never affect each other.
- R10: The gate and status outputs fall together, at the clock edge where the qualifying sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch1_smp | input | SW | Channel 1 sample |
| ch2_smp | input | SW | Channel 2 sample |
| ch3_smp | input | SW | Channel 3 sample |
| ch4_smp | input | SW | Channel 4 sample |
| line_smp | input | SW | Line-rate reference sample |
| m_sel | input | 3 | Main channel source select |
| m_level | input | SW | Main channel trigger level |
| m_hold | input | 1 | Main channel holdoff, high disarms and clears |
| m_ld | input | 1 | Main channel control load strobe |
| m_slope_in | input | 1 | Slope value to load (0 rising, 1 falling) |
| m_auto_in | input | 1 | Auto enable value to load |
| m_tmo_in | input | TOW | Auto timeout value to load, in armed cycles |
| m_gate_n | output | 1 | Main trigger gate, active low |
| m_stat_n | output | 1 | Main trigger status, active low |
| d_sel | input | 3 | Delayed channel source select |
| d_level | input | SW | Delayed channel trigger level |
| d_hold | input | 1 | Delayed channel holdoff |
| d_ld | input | 1 | Delayed channel control load strobe |
| d_slope_in | input | 1 | Slope value to load |
| d_auto_in | input | 1 | Auto enable value to load |
| d_tmo_in | input | TOW | Auto timeout value to load |
| d_gate_n | output | 1 | Delayed trigger gate, active low |
| d_stat_n | output | 1 | Delayed trigger status, active low |

## Verification
On every cycle, the bound checker confirms four things for each channel. Holdoff high forces both outputs high at the next edge. A fired channel stays fired while holdoff is low. Gate and status always agree. A gate can only fall after an edge with holdoff low, and never while an unused select code is applied. The source map, the saturating sum, the exact crossing rules including the equality cases, the first-sample capture, the auto timeout count and the strobe-only control loading all depend on specific data values and sequences, so only the directed scenarios can demonstrate them.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [2:0] {
      SRC_NONE0 = 3'b000,
      SRC_CH4   = 3'b001,
      SRC_CH3   = 3'b010,
      SRC_NONE3 = 3'b011,
      SRC_SUM   = 3'b100,
      SRC_CH2   = 3'b101,
      SRC_CH1   = 3'b110,
      SRC_LINE  = 3'b111
   } src_sel_e;

   localparam int SEL_W = 3;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux
   import trig_pkg::*;
#(
   parameter int SW      = 8,
   parameter bit SAT_SUM = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [SW-1:0]    ch1,
   input  logic [SW-1:0]    ch2,
   input  logic [SW-1:0]    ch3,
   input  logic [SW-1:0]    ch4,
   input  logic [SW-1:0]    line,
   output logic [SW-1:0]    smp,
   output logic             smp_ok
);
   localparam int WIDE = SW + 1;

   logic [WIDE-1:0] raw_sum;
   logic [SW-1:0]   sum_val;

   assign raw_sum = {1'b0, ch1} + {1'b0, ch2};

   generate
      if (SAT_SUM) begin : g_sat
         assign sum_val = raw_sum[SW] ? {SW{1'b1}} : raw_sum[SW-1:0];
      end else begin : g_wrap
         assign sum_val = raw_sum[SW-1:0];
      end
   endgenerate

   always_comb begin
      smp    = '0;
      smp_ok = 1'b1;
      unique case (src_sel_e'(sel))
         SRC_CH1:  smp = ch1;
         SRC_CH2:  smp = ch2;
         SRC_SUM:  smp = sum_val;
         SRC_CH3:  smp = ch3;
         SRC_CH4:  smp = ch4;
         SRC_LINE: smp = line;
         default:  smp_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/trig_ctl_reg.sv
module trig_ctl_reg #(
   parameter int TOW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic           slope_in,
   input  logic           auto_in,
   input  logic [TOW-1:0] tmo_in,
   output logic           slope,
   output logic           auto_en,
   output logic [TOW-1:0] tmo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slope   <= 1'b0;
         auto_en <= 1'b0;
         tmo     <= '0;
      end else if (ld) begin
         slope   <= slope_in;
         auto_en <= auto_in;
         tmo     <= tmo_in;
      end
   end
endmodule

// File: rtl/trig_detect.sv
module trig_detect #(
   parameter int SW  = 8,
   parameter int TOW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic [SW-1:0]  cur,
   input  logic           cur_ok,
   input  logic [SW-1:0]  level,
   input  logic           slope,
   input  logic           auto_en,
   input  logic [TOW-1:0] tmo,
   output logic           gate_n,
   output logic           stat_n
);
   logic [SW-1:0]  prev;
   logic           prev_ok;
   logic           fired_g;
   logic           fired_s;
   logic [TOW-1:0] cnt;
   logic           rise_hit;
   logic           fall_hit;
   logic           edge_hit;
   logic           tmo_hit;

   assign rise_hit = (prev < level) && (cur >= level);
   assign fall_hit = (prev >= level) && (cur < level);
   assign edge_hit = cur_ok && prev_ok && (slope ? fall_hit : rise_hit);
   assign tmo_hit  = cur_ok && auto_en && (tmo != '0) && (cnt == tmo - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev    <= '0;
         prev_ok <= 1'b0;
         fired_g <= 1'b0;
         fired_s <= 1'b0;
         cnt     <= '0;
      end else if (hold) begin
         prev_ok <= 1'b0;
         fired_g <= 1'b0;
         fired_s <= 1'b0;
         cnt     <= '0;
      end else begin
         prev    <= cur;
         prev_ok <= cur_ok;
         if (!fired_g) begin
            if (edge_hit || tmo_hit) begin
               fired_g <= 1'b1;
               fired_s <= 1'b1;
            end else if (cur_ok) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign gate_n = ~fired_g;
   assign stat_n = ~fired_s;
endmodule

// File: rtl/trig_channel.sv
module trig_channel
   import trig_pkg::*;
#(
   parameter int SW      = 8,
   parameter int TOW     = 16,
   parameter bit SAT_SUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SW-1:0]    ch1,
   input  logic [SW-1:0]    ch2,
   input  logic [SW-1:0]    ch3,
   input  logic [SW-1:0]    ch4,
   input  logic [SW-1:0]    line,
   input  logic [SEL_W-1:0] sel,
   input  logic [SW-1:0]    level,
   input  logic             hold,
   input  logic             ld,
   input  logic             slope_in,
   input  logic             auto_in,
   input  logic [TOW-1:0]   tmo_in,
   output logic             gate_n,
   output logic             stat_n
);
   logic [SW-1:0]  smp;
   logic           smp_ok;
   logic           slope;
   logic           auto_en;
   logic [TOW-1:0] tmo;

   trig_src_mux #(.SW(SW), .SAT_SUM(SAT_SUM)) u_mux (
      .sel(sel), .ch1(ch1), .ch2(ch2), .ch3(ch3), .ch4(ch4), .line(line),
      .smp(smp), .smp_ok(smp_ok)
   );

   trig_ctl_reg #(.TOW(TOW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ld(ld), .slope_in(slope_in),
      .auto_in(auto_in), .tmo_in(tmo_in),
      .slope(slope), .auto_en(auto_en), .tmo(tmo)
   );

   trig_detect #(.SW(SW), .TOW(TOW)) u_det (
      .clk(clk), .rst_n(rst_n), .hold(hold), .cur(smp), .cur_ok(smp_ok),
      .level(level), .slope(slope), .auto_en(auto_en), .tmo(tmo),
      .gate_n(gate_n), .stat_n(stat_n)
   );
endmodule

// File: rtl/dual_trig_unit.sv
module dual_trig_unit #(
   parameter int SW      = 8,
   parameter int TOW     = 16,
   parameter bit SAT_SUM = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [SW-1:0]  ch1_smp,
   input  logic [SW-1:0]  ch2_smp,
   input  logic [SW-1:0]  ch3_smp,
   input  logic [SW-1:0]  ch4_smp,
   input  logic [SW-1:0]  line_smp,
   input  logic [2:0]     m_sel,
   input  logic [SW-1:0]  m_level,
   input  logic           m_hold,
   input  logic           m_ld,
   input  logic           m_slope_in,
   input  logic           m_auto_in,
   input  logic [TOW-1:0] m_tmo_in,
   output logic           m_gate_n,
   output logic           m_stat_n,
   input  logic [2:0]     d_sel,
   input  logic [SW-1:0]  d_level,
   input  logic           d_hold,
   input  logic           d_ld,
   input  logic           d_slope_in,
   input  logic           d_auto_in,
   input  logic [TOW-1:0] d_tmo_in,
   output logic           d_gate_n,
   output logic           d_stat_n
);
   localparam int NCH = 2;

   generate
      if (SW < 2) begin : g_bad_sw
         $error("dual_trig_unit: SW must be at least 2");
      end
      if (TOW < 1) begin : g_bad_tow
         $error("dual_trig_unit: TOW must be at least 1");
      end
   endgenerate

   logic [NCH-1:0][2:0]     sel_a;
   logic [NCH-1:0][SW-1:0]  lvl_a;
   logic [NCH-1:0]          hold_a, ld_a, slope_a, auto_a, gate_a, stat_a;
   logic [NCH-1:0][TOW-1:0] tmo_a;

   assign sel_a   = {d_sel, m_sel};
   assign lvl_a   = {d_level, m_level};
   assign hold_a  = {d_hold, m_hold};
   assign ld_a    = {d_ld, m_ld};
   assign slope_a = {d_slope_in, m_slope_in};
   assign auto_a  = {d_auto_in, m_auto_in};
   assign tmo_a   = {d_tmo_in, m_tmo_in};

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         trig_channel #(.SW(SW), .TOW(TOW), .SAT_SUM(SAT_SUM)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ch1(ch1_smp), .ch2(ch2_smp), .ch3(ch3_smp), .ch4(ch4_smp),
            .line(line_smp),
            .sel(sel_a[i]), .level(lvl_a[i]), .hold(hold_a[i]), .ld(ld_a[i]),
            .slope_in(slope_a[i]), .auto_in(auto_a[i]), .tmo_in(tmo_a[i]),
            .gate_n(gate_a[i]), .stat_n(stat_a[i])
         );
      end
   endgenerate

   assign m_gate_n = gate_a[0];
   assign m_stat_n = stat_a[0];
   assign d_gate_n = gate_a[1];
   assign d_stat_n = stat_a[1];
endmodule

// File: rtl/dual_trig_unit_chk.sv
module dual_trig_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] m_sel,
   input logic       m_hold,
   input logic       m_gate_n,
   input logic       m_stat_n,
   input logic [2:0] d_sel,
   input logic       d_hold,
   input logic       d_gate_n,
   input logic       d_stat_n
);
   logic m_bad, d_bad;
   assign m_bad = (m_sel == 3'b000) || (m_sel == 3'b011);
   assign d_bad = (d_sel == 3'b000) || (d_sel == 3'b011);

   p_hold_clears_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
      m_hold |=> (m_gate_n && m_stat_n));
   p_hold_clears_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
      d_hold |=> (d_gate_n && d_stat_n));

   p_latched_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_gate_n && !m_hold) |=> !m_gate_n);
   p_latched_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_gate_n && !d_hold) |=> !d_gate_n);

   p_fall_armed_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(m_gate_n) |-> !$past(m_hold));
   p_fall_armed_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(d_gate_n) |-> !$past(d_hold));

   p_pair_m_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_gate_n == m_stat_n);
   p_pair_d_r10: assert property (@(posedge clk) disable iff (!rst_n)
      d_gate_n == d_stat_n);

   p_unused_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_bad && m_gate_n) |=> m_gate_n);
   p_unused_d_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_bad && d_gate_n) |=> d_gate_n);
endmodule

bind dual_trig_unit dual_trig_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .m_sel(m_sel), .m_hold(m_hold), .m_gate_n(m_gate_n), .m_stat_n(m_stat_n),
   .d_sel(d_sel), .d_hold(d_hold), .d_gate_n(d_gate_n), .d_stat_n(d_stat_n)
);

// File: tb/sim_dual_trig_unit.sv
`timescale 1ns/1ps
module sim_dual_trig_unit;
   localparam int SW  = 8;
   localparam int TOW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SW-1:0] ch1 = '0, ch2 = '0, ch3 = '0, ch4 = '0, line = '0;
   logic [2:0] m_sel = 3'b110, d_sel = 3'b110;
   logic [SW-1:0] m_level = '0, d_level = '0;
   logic m_hold = 1'b1, d_hold = 1'b1, m_ld = 1'b0, d_ld = 1'b0;
   logic m_slope = 1'b0, d_slope = 1'b0, m_auto = 1'b0, d_auto = 1'b0;
   logic [TOW-1:0] m_tmo = '0, d_tmo = '0;
   logic m_gate_n, m_stat_n, d_gate_n, d_stat_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dual_trig_unit #(.SW(SW), .TOW(TOW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ch1_smp(ch1), .ch2_smp(ch2), .ch3_smp(ch3), .ch4_smp(ch4), .line_smp(line),
      .m_sel(m_sel), .m_level(m_level), .m_hold(m_hold), .m_ld(m_ld),
      .m_slope_in(m_slope), .m_auto_in(m_auto), .m_tmo_in(m_tmo),
      .m_gate_n(m_gate_n), .m_stat_n(m_stat_n),
      .d_sel(d_sel), .d_level(d_level), .d_hold(d_hold), .d_ld(d_ld),
      .d_slope_in(d_slope), .d_auto_in(d_auto), .d_tmo_in(d_tmo),
      .d_gate_n(d_gate_n), .d_stat_n(d_stat_n)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_src(input int idx, input logic [SW-1:0] v);
      case (idx)
         1: ch1 = v;
         2: ch2 = v;
         3: ch3 = v;
         4: ch4 = v;
         default: line = v;
      endcase
   endtask

   task automatic clear_srcs();
      ch1 = '0; ch2 = '0; ch3 = '0; ch4 = '0; line = '0;
   endtask

   task automatic load_m(input logic s, input logic a, input logic [TOW-1:0] t);
      m_slope = s; m_auto = a; m_tmo = t; m_ld = 1'b1;
      step();
      m_ld = 1'b0; m_slope = 1'b0; m_auto = 1'b0; m_tmo = '0;
   endtask

   task automatic load_d(input logic s, input logic a, input logic [TOW-1:0] t);
      d_slope = s; d_auto = a; d_tmo = t; d_ld = 1'b1;
      step();
      d_ld = 1'b0; d_slope = 1'b0; d_auto = 1'b0; d_tmo = '0;
   endtask

   task automatic release_m();
      m_hold = 1'b1;
      step();
   endtask

   task automatic t_reset();
      chk("R1", "m_gate_n after reset", m_gate_n, 1'b1);
      chk("R1", "m_stat_n after reset", m_stat_n, 1'b1);
      chk("R1", "d_gate_n after reset", d_gate_n, 1'b1);
      chk("R1", "d_stat_n after reset", d_stat_n, 1'b1);
   endtask

   // R4 R10 R6 on channel 1, plus R9: strobe-less control inputs ignored
   task automatic t_rise_ch1();
      clear_srcs();
      m_sel = 3'b110; m_level = 8'd100;
      m_slope = 1'b1; m_auto = 1'b1; m_tmo = 16'd1;   // no strobe: must be ignored
      ch1 = 8'd150; m_hold = 1'b0;
      step();
      chk("R6", "first armed sample only captured", m_gate_n, 1'b1);
      ch1 = 8'd50; step();
      chk("R9", "no fire on falling with slope 0 (unloaded)", m_gate_n, 1'b1);
      ch1 = 8'd150; step();
      chk("R4", "rising crossing fires gate", m_gate_n, 1'b0);
      chk("R10", "status falls with gate", m_stat_n, 1'b0);
      chk("R9", "delayed channel untouched", d_gate_n, 1'b1);
      ch1 = 8'd0; step();
      chk("R6", "gate latched after source drops", m_gate_n, 1'b0);
      m_slope = 1'b0; m_auto = 1'b0; m_tmo = '0;
      m_hold = 1'b1; step();
      chk("R6", "holdoff returns gate high", m_gate_n, 1'b1);
      chk("R6", "holdoff returns status high", m_stat_n, 1'b1);
   endtask

   task automatic t_equal_rise();
      clear_srcs(); load_m(1'b0, 1'b0, '0);
      m_sel = 3'b110; m_level = 8'd100; ch1 = 8'd99; m_hold = 1'b0;
      step(); ch1 = 8'd100; step();
      chk("R4", "sample equal to level counts as at-or-above", m_gate_n, 1'b0);
      release_m();
   endtask

   task automatic t_fall_ch2();
      clear_srcs(); load_m(1'b1, 1'b0, '0);
      m_sel = 3'b101; m_level = 8'd100; ch2 = 8'd90; m_hold = 1'b0;
      step(); ch2 = 8'd120; step();
      chk("R5", "rising ignored with slope 1", m_gate_n, 1'b1);
      ch2 = 8'd100; step();
      chk("R5", "no fire while staying at level", m_gate_n, 1'b1);
      ch2 = 8'd99; step();
      chk("R5", "falling crossing fires with slope 1", m_gate_n, 1'b0);
      chk("R10", "status with falling fire", m_stat_n, 1'b0);
      release_m();
   endtask

   task automatic t_src(input logic [2:0] code, input int idx, input string nm);
      clear_srcs(); load_m(1'b0, 1'b0, '0);
      m_sel = code; m_level = 8'd128; m_hold = 1'b0;
      step();
      set_src(idx, 8'd200); step();
      chk("R2", nm, m_gate_n, 1'b0);
      release_m();
   endtask

   task automatic t_wrong_src();
      clear_srcs(); load_m(1'b0, 1'b0, '0);
      m_sel = 3'b110; m_level = 8'd128; m_hold = 1'b0;
      for (int k = 0; k < 6; k++) begin
         ch2 = (k % 2) ? 8'd200 : 8'd0;
         ch3 = ch2; ch4 = ch2; line = ch2;
         step();
      end
      chk("R2", "crossings on unselected sources ignored", m_gate_n, 1'b1);
      release_m();
   endtask

   task automatic t_sum();
      clear_srcs(); load_m(1'b0, 1'b0, '0);
      m_sel = 3'b100; m_level = 8'd255; m_hold = 1'b0;
      step();
      ch1 = 8'd200; ch2 = 8'd200; step();
      chk("R3", "overflowing sum saturates to all ones", m_gate_n, 1'b0);
      release_m();
      clear_srcs();
      m_level = 8'd150; m_hold = 1'b0; step();
      ch1 = 8'd100; ch2 = 8'd49; step();
      chk("R3", "sum 149 below level 150", m_gate_n, 1'b1);
      ch2 = 8'd50; step();
      chk("R3", "sum 150 reaches level 150", m_gate_n, 1'b0);
      release_m();
   endtask

   task automatic t_unused();
      load_m(1'b0, 1'b1, 16'd2);
      for (int c = 0; c < 2; c++) begin
         clear_srcs();
         m_sel = (c == 0) ? 3'b000 : 3'b011;
         m_level = 8'd100; m_hold = 1'b0;
         for (int k = 0; k < 8; k++) begin
            ch1 = (k % 2) ? 8'd255 : 8'd0;
            ch2 = ch1; ch3 = ch1; ch4 = ch1; line = ch1;
            step();
         end
         chk("R7", (c == 0) ? "code 000 never fires" : "code 011 never fires", m_gate_n, 1'b1);
         release_m();
      end
   endtask

   task automatic t_auto();
      clear_srcs(); load_m(1'b0, 1'b1, 16'd5);
      m_sel = 3'b110; m_level = 8'd100; ch1 = 8'd10; m_hold = 1'b0;
      for (int k = 0; k < 4; k++) step();
      chk("R8", "no auto fire before 5 armed edges", m_gate_n, 1'b1);
      step();
      chk("R8", "auto fire at 5th armed edge", m_gate_n, 1'b0);
      release_m();
      load_m(1'b0, 1'b1, 16'd0);
      m_hold = 1'b0;
      for (int k = 0; k < 20; k++) step();
      chk("R8", "timeout 0 disables auto", m_gate_n, 1'b1);
      release_m();
   endtask

   task automatic t_hold_blocks();
      clear_srcs(); load_m(1'b0, 1'b0, '0);
      m_sel = 3'b110; m_level = 8'd100; m_hold = 1'b1;
      for (int k = 0; k < 6; k++) begin
         ch1 = (k % 2) ? 8'd200 : 8'd0;
         step();
      end
      chk("R6", "no trigger while holdoff high", m_gate_n, 1'b1);
   endtask

   task automatic t_delayed();
      clear_srcs(); load_d(1'b0, 1'b0, '0);
      d_sel = 3'b001; d_level = 8'd50; d_hold = 1'b0;
      m_sel = 3'b110; m_level = 8'd100; m_hold = 1'b0;
      step(); ch4 = 8'd60; step();
      chk("R9", "delayed channel fires on channel 4", d_gate_n, 1'b0);
      chk("R10", "delayed status with gate", d_stat_n, 1'b0);
      chk("R9", "main channel unaffected", m_gate_n, 1'b1);
      d_hold = 1'b1; m_hold = 1'b1; step();
      chk("R6", "delayed cleared by its holdoff", d_gate_n, 1'b1);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_rise_ch1();
      t_equal_rise();
      t_fall_ch2();
      t_src(3'b110, 1, "code 110 selects channel 1");
      t_src(3'b101, 2, "code 101 selects channel 2");
      t_src(3'b010, 3, "code 010 selects channel 3");
      t_src(3'b001, 4, "code 001 selects channel 4");
      t_src(3'b111, 5, "code 111 selects line source");
      t_wrong_src();
      t_sum();
      t_unused();
      t_auto();
      t_hold_blocks();
      t_delayed();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule